// File: doc/BRIEF.md
# Configurable Product-Term Array

This block is the combinational AND-OR plane of one programmable logic block. A set of array inputs enters in both true and complement form. A programmable AND plane combines a chosen subset of those literals into each product term. A steering stage then ORs a programmable subset of the product terms into each macrocell sum. Any sum may draw on any product term, and one term may feed several sums at the same time. The number of terms a single sum may draw on is capped.

The configuration is a single flat bit vector. It enters one bit per clock through a serial port into a shadow register. A load strobe copies the shadow into the active configuration, but only when every sum respects the term cap. A failed load raises an error flag and leaves the array running on its previous pattern. The sums are a pure combinational function of the inputs and the active configuration.

The defaults give 36 inputs, 86 product terms, 16 sums and a cap of 16 terms per sum.

Top module: `pt_array_block`

## Requirements
- R1: Product term t is the AND of its enabled literals. The enable for the true literal of input i is configuration bit t*2*N_IN + 2*i, and the enable for its complement is bit t*2*N_IN + 2*i + 1. A term with no enabled literal evaluates to 1.
- R2: A term that enables both the true and the complement literal of the same input evaluates to 0 for every input value.
- R3: Sum s is the OR of the product terms whose steering bit N_TERM*2*N_IN + s*N_TERM + t is set. A sum with no steering bit set is 0.
- R4: One product term may be steered into several sums at once, and each of those sums reflects it.
- R5: While cfg_shift is high, each clock shifts cfg_bit into the shadow register from the low end. After CFG_W shifts, the first bit sent sits at configuration bit CFG_W-1, so the pattern is sent most significant bit first.
- R6: A cfg_load pulse copies the shadow register into the active configuration on that clock edge when no sum selects more than MAX_TERMS terms. A sum may select exactly MAX_TERMS terms. After an accepted load, cfg_err is 0.
- R7: A cfg_load pulse while some sum selects more than MAX_TERMS terms sets cfg_err and leaves the active configuration, and therefore every sum, unchanged. cfg_err stays set until the next load or reset.
- R8: An active-low asynchronous reset clears the shadow register, the active configuration and cfg_err, which forces every sum to 0.
- R9: Shifting without a load pulse does not change any sum output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shift | input | 1 | Shift enable for the serial configuration port |
| cfg_bit | input | 1 | Serial configuration data bit |
| cfg_load | input | 1 | Strobe that transfers shadow to active configuration |
| in_vec | input | N_IN | Array inputs |
| sum_out | output | N_SUM | Macrocell sums |
| cfg_err | output | 1 | Last load was rejected for exceeding the term cap |

## Verification
The bench builds the block with 3 inputs, 5 product terms, 3 sums and a cap of 2 terms per sum. This makes the bitstream only 45 bits long. Every one of the 8 input vectors can then be swept after each load, and a single term or a single sum can be pushed across the cap with only one extra steering bit. Hand-built patterns cover the constant-one term, the contradictory term, a shared term, and a sum at exactly the cap. A run of pseudo-random bitstreams then mixes accepted and rejected loads. For each one, the bench decides arithmetically whether the load should be accepted.

// File: rtl/pt_array_pkg.sv
package pt_array_pkg;
   // Width of the literal columns for a given input count
   function automatic int lit_width(input int n_in);
      return 2 * n_in;
   endfunction

   // Bits of the AND plane: one enable per literal per term
   function automatic int and_width(input int n_in, input int n_term);
      return 2 * n_in * n_term;
   endfunction

   // Total configuration: AND plane followed by the steering matrix
   function automatic int cfg_width(input int n_in, input int n_term, input int n_sum);
      return 2 * n_in * n_term + n_sum * n_term;
   endfunction
endpackage

// File: rtl/pt_cfg_store.sv
module pt_cfg_store #(
   parameter int N_TERM    = 86,
   parameter int N_SUM     = 16,
   parameter int MAX_TERMS = 16,
   parameter int AND_W     = 6192,
   parameter int CFG_W     = 7568
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_shift,
   input  logic             cfg_bit,
   input  logic             cfg_load,
   output logic [CFG_W-1:0] shadow_q,
   output logic [CFG_W-1:0] active_q,
   output logic             cfg_err
);
   localparam int CNT_W = $clog2(N_TERM + 1);

   logic [N_SUM-1:0] over_cap;

   // Per-sum population count of the shadow steering slice
   for (genvar s = 0; s < N_SUM; s++) begin : g_cap
      logic [CNT_W-1:0] cnt;
      always_comb begin
         cnt = '0;
         for (int t = 0; t < N_TERM; t++) begin
            cnt = cnt + CNT_W'(shadow_q[AND_W + s*N_TERM + t]);
         end
      end
      assign over_cap[s] = (32'(cnt) > MAX_TERMS);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
      end else if (cfg_shift) begin
         shadow_q <= {shadow_q[CFG_W-2:0], cfg_bit};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= '0;
         cfg_err  <= 1'b0;
      end else if (cfg_load) begin
         if (|over_cap) begin
            cfg_err <= 1'b1;
         end else begin
            active_q <= shadow_q;
            cfg_err  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pt_and_plane.sv
module pt_and_plane #(
   parameter int N_IN   = 36,
   parameter int N_TERM = 86,
   parameter int LIT_W  = 72
) (
   input  logic [N_IN-1:0]         in_vec,
   input  logic [N_TERM*LIT_W-1:0] and_cfg,
   output logic [N_TERM-1:0]       term
);
   logic [LIT_W-1:0] lits;

   for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign lits[2*i]   = in_vec[i];
      assign lits[2*i+1] = ~in_vec[i];
   end

   // A disabled literal is forced to 1 so it drops out of the AND
   for (genvar t = 0; t < N_TERM; t++) begin : g_term
      assign term[t] = &(lits | ~and_cfg[t*LIT_W +: LIT_W]);
   end
endmodule

// File: rtl/pt_steer.sv
module pt_steer #(
   parameter int N_TERM = 86,
   parameter int N_SUM  = 16
) (
   input  logic [N_TERM-1:0]       term,
   input  logic [N_SUM*N_TERM-1:0] sel_cfg,
   output logic [N_SUM-1:0]        sum_out
);
   for (genvar s = 0; s < N_SUM; s++) begin : g_sum
      assign sum_out[s] = |(term & sel_cfg[s*N_TERM +: N_TERM]);
   end
endmodule

// File: rtl/pt_array_block.sv
module pt_array_block
   import pt_array_pkg::*;
#(
   parameter int N_IN      = 36,
   parameter int N_TERM    = 86,
   parameter int N_SUM     = 16,
   parameter int MAX_TERMS = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_shift,
   input  logic            cfg_bit,
   input  logic            cfg_load,
   input  logic [N_IN-1:0] in_vec,
   output logic [N_SUM-1:0] sum_out,
   output logic            cfg_err
);
   localparam int LIT_W = lit_width(N_IN);
   localparam int AND_W = and_width(N_IN, N_TERM);
   localparam int CFG_W = cfg_width(N_IN, N_TERM, N_SUM);

   if (N_IN < 1 || N_TERM < 1 || N_SUM < 1) begin : g_bad_dims
      $error("pt_array_block: every dimension must be at least 1");
   end
   if (MAX_TERMS < 1 || MAX_TERMS > N_TERM) begin : g_bad_cap
      $error("pt_array_block: MAX_TERMS must lie in 1..N_TERM");
   end

   logic [CFG_W-1:0]  shadow_q;
   logic [CFG_W-1:0]  active_q;
   logic [N_TERM-1:0] term;

   pt_cfg_store #(
      .N_TERM(N_TERM), .N_SUM(N_SUM), .MAX_TERMS(MAX_TERMS),
      .AND_W(AND_W), .CFG_W(CFG_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_bit(cfg_bit),
      .cfg_load(cfg_load), .shadow_q(shadow_q), .active_q(active_q),
      .cfg_err(cfg_err)
   );

   pt_and_plane #(
      .N_IN(N_IN), .N_TERM(N_TERM), .LIT_W(LIT_W)
   ) u_and (
      .in_vec(in_vec), .and_cfg(active_q[AND_W-1:0]), .term(term)
   );

   pt_steer #(
      .N_TERM(N_TERM), .N_SUM(N_SUM)
   ) u_steer (
      .term(term), .sel_cfg(active_q[CFG_W-1:AND_W]), .sum_out(sum_out)
   );
endmodule

// File: rtl/pt_array_chk.sv
module pt_array_chk #(
   parameter int N_IN      = 36,
   parameter int N_TERM    = 86,
   parameter int N_SUM     = 16,
   parameter int MAX_TERMS = 16,
   parameter int AND_W     = 6192,
   parameter int CFG_W     = 7568
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_shift,
   input logic             cfg_bit,
   input logic             cfg_load,
   input logic [N_IN-1:0]  in_vec,
   input logic [N_SUM-1:0] sum_out,
   input logic             cfg_err,
   input logic [CFG_W-1:0] shadow_q,
   input logic [CFG_W-1:0] active_q
);
   // R5: the serial bit enters the low end of the shadow
   p_shift_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_shift |=> shadow_q[0] == $past(cfg_bit));

   // R6: an accepted load mirrors the shadow
   p_load_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> (cfg_err || active_q == $past(shadow_q)));

   // R7: a rejected load leaves the active pattern alone
   p_reject_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> (!cfg_err || $stable(active_q)));

   // R7 R9: without a load strobe neither the pattern nor the flag moves
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load |=> ($stable(active_q) && $stable(cfg_err)));

   for (genvar s = 0; s < N_SUM; s++) begin : g_sum_chk
      // R6: an active pattern never exceeds the cap
      p_cap_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(active_q[AND_W + s*N_TERM +: N_TERM]) <= MAX_TERMS);
      // R3: no steered term means a zero sum
      p_empty_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (active_q[AND_W + s*N_TERM +: N_TERM] == '0) |-> !sum_out[s]);
   end
endmodule

bind pt_array_block pt_array_chk #(
   .N_IN(N_IN), .N_TERM(N_TERM), .N_SUM(N_SUM), .MAX_TERMS(MAX_TERMS),
   .AND_W(AND_W), .CFG_W(CFG_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_bit(cfg_bit),
   .cfg_load(cfg_load), .in_vec(in_vec), .sum_out(sum_out), .cfg_err(cfg_err),
   .shadow_q(shadow_q), .active_q(active_q)
);

// File: tb/pt_array_block_bench.sv
module pt_array_block_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NI = 3;
   localparam int NT = 5;
   localparam int NS = 3;
   localparam int MX = 2;
   localparam int LW = 2 * NI;
   localparam int AW = LW * NT;
   localparam int CW = AW + NS * NT;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_shift = 1'b0;
   logic cfg_bit = 1'b0;
   logic cfg_load = 1'b0;
   logic [NI-1:0] in_vec = '0;
   logic [NS-1:0] sum_out;
   logic cfg_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   bit [CW-1:0] cfg;
   bit [CW-1:0] exp_active;
   bit          exp_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   pt_array_block #(.N_IN(NI), .N_TERM(NT), .N_SUM(NS), .MAX_TERMS(MX)) u_pt_array_block (
      .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_bit(cfg_bit),
      .cfg_load(cfg_load), .in_vec(in_vec), .sum_out(sum_out), .cfg_err(cfg_err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
      end
   endtask

   function automatic bit model_sum(bit [CW-1:0] c, int s, bit [NI-1:0] x);
      for (int t = 0; t < NT; t++) begin
         bit tv = 1'b1;
         for (int i = 0; i < NI; i++) begin
            if (c[t*LW + 2*i] && !x[i]) tv = 1'b0;
            if (c[t*LW + 2*i + 1] && x[i]) tv = 1'b0;
         end
         if (tv && c[AW + s*NT + t]) return 1'b1;
      end
      return 1'b0;
   endfunction

   function automatic bit fits_cap(bit [CW-1:0] c);
      for (int s = 0; s < NS; s++) begin
         int n = 0;
         for (int t = 0; t < NT; t++) n += int'(c[AW + s*NT + t]);
         if (n > MX) return 1'b0;
      end
      return 1'b1;
   endfunction

   task automatic lit(input int t, input int i, input bit comp);
      cfg[t*LW + 2*i + int'(comp)] = 1'b1;
   endtask

   task automatic steer(input int s, input int t);
      cfg[AW + s*NT + t] = 1'b1;
   endtask

   task automatic shift_bits(input bit [CW-1:0] v, input int n);
      for (int b = CW - 1; b > CW - 1 - n; b--) begin
         @(negedge clk);
         cfg_shift = 1'b1;
         cfg_bit = v[b];
      end
      @(negedge clk);
      cfg_shift = 1'b0;
   endtask

   task automatic load_cfg(input bit [CW-1:0] v);
      shift_bits(v, CW);
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      if (fits_cap(v)) begin
         exp_active = v;
         exp_err = 1'b0;
      end else begin
         exp_err = 1'b1;
      end
   endtask

   task automatic sweep(input string req);
      for (int x = 0; x < (1 << NI); x++) begin
         @(negedge clk);
         in_vec = NI'(x);
         #1;
         for (int s = 0; s < NS; s++) begin
            bit e = model_sum(exp_active, s, NI'(x));
            check(sum_out[s] == e, req, int'(sum_out[s]), int'(e));
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      exp_active = '0;
      exp_err = 1'b0;
      repeat (3) @(negedge clk);
      // R8: reset state
      check(cfg_err == 1'b0, "R8", int'(cfg_err), 0);
      sweep("R8");
      rst_n = 1'b1;
      @(negedge clk);
      sweep("R8");

      // Pattern A: R1 single literals and constant term, R2 contradiction,
      // R3 empty sum, R4 term 1 shared, R6 sum at exactly the cap
      cfg = '0;
      lit(0, 0, 1'b0);
      lit(1, 1, 1'b1);
      lit(3, 0, 1'b0); lit(3, 0, 1'b1);
      lit(4, 2, 1'b0); lit(4, 1, 1'b0);
      steer(0, 0); steer(0, 1);
      steer(1, 1); steer(1, 4);
      load_cfg(cfg);
      check(cfg_err == 1'b0, "R6", int'(cfg_err), 0);
      sweep("R1 R3 R4 R6");

      // Pattern B: R1 constant-one term, R2 contradiction alone
      cfg = '0;
      lit(0, 2, 1'b1);
      lit(3, 1, 1'b0); lit(3, 1, 1'b1);
      lit(4, 0, 1'b1); lit(4, 2, 1'b0);
      steer(2, 2);
      steer(0, 3);
      steer(1, 0); steer(1, 4);
      load_cfg(cfg);
      check(cfg_err == 1'b0, "R6", int'(cfg_err), 0);
      sweep("R1 R2");

      // R9: partial shift of a new pattern with no load
      cfg = '1;
      shift_bits(cfg, 20);
      repeat (3) @(negedge clk);
      sweep("R9");

      // R7: sum 0 asks for three terms
      cfg = '0;
      steer(0, 0); steer(0, 1); steer(0, 2);
      steer(2, 2);
      load_cfg(cfg);
      check(cfg_err == 1'b1, "R7", int'(cfg_err), 1);
      sweep("R7");
      repeat (4) @(negedge clk);
      check(cfg_err == 1'b1, "R7", int'(cfg_err), 1);

      // R6: a good load clears the flag
      cfg = '0;
      lit(2, 0, 1'b1); lit(2, 1, 1'b1);
      steer(0, 2); steer(1, 2); steer(2, 2);
      load_cfg(cfg);
      check(cfg_err == 1'b0, "R6", int'(cfg_err), 0);
      sweep("R4 R6");

      // R5 R6 R7: pseudo-random bitstreams
      begin
         bit [31:0] r = 32'h1d2c_3b4a;
         for (int k = 0; k < 40; k++) begin
            for (int b = 0; b < CW; b++) begin
               r ^= r << 13; r ^= r >> 17; r ^= r << 5;
               cfg[b] = (b < AW) ? (r[1:0] == 2'b00) : (r % 3 == 0);
            end
            load_cfg(cfg);
            check(cfg_err == exp_err, "R5 R6 R7", int'(cfg_err), int'(exp_err));
            sweep("R5");
         end
      end

      // R8: reset in the middle of operation
      @(negedge clk);
      rst_n = 1'b0;
      exp_active = '0;
      #1;
      check(cfg_err == 1'b0, "R8", int'(cfg_err), 0);
      sweep("R8");
      rst_n = 1'b1;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule